// File: doc/BRIEF.md
# Serial Output Power and Lock Sequencer

This block decides what the serial line driver of a parallel-to-serial link does. It takes a power-down input, a flag that says the input supply is present, and the parallel clock. From these it selects one of three output states. In OFF the driver is in high impedance, the termination is switched out and the PLL is stopped. In LOCK_WAIT the termination is switched in, the PLL runs and the line is held at zero differential. In DRIVE the driver is enabled and the framer is released.

The time from leaving power-down to the first driven output is set by an internal lock-wait counter. The counter runs for a fixed number of parallel-clock cycles; it does not detect phase. The counter value is brought out as a status output. The analog termination and the real PLL lie outside the block and are represented only by enable signals.

Named transitions: OFF to LOCK_WAIT on request-up, LOCK_WAIT to DRIVE on lock-done, and LOCK_WAIT or DRIVE to OFF on request-down.

Top module: `link_power_seq`

## Requirements
- R1: While `rst_n` is low, the block is in OFF: `drv_en`, `term_en`, `pll_run` and `ready` are 0 and `lock_count` is 0. Reset takes effect without waiting for a clock edge.
- R2: In OFF, `drv_en`, `term_en`, `pll_run` and `ready` are all 0 and `lock_count` stays at 0.
- R3: The effective request is `pwr_run` AND `vin_ok`. When `vin_ok` is 0, the block behaves as if `pwr_run` were 0, whatever the level of `pwr_run`.
- R4: The request passes through a two-flop synchronizer. A change applied before rising edge E changes the state at edge E+2. On edges E and E+1 the state is unchanged.
- R5: In LOCK_WAIT, `term_en` and `pll_run` are 1 and `drv_en` and `ready` are 0. `lock_count` is 0 on the first cycle and rises by one on each clock.
- R6: LOCK_WAIT lasts LOCK_CYCLES (16385) cycles. `drv_en` and `ready` rise together on the cycle in which `lock_count` reaches 16385, and `lock_count` never exceeds 16385.
- R7: In DRIVE, all four control outputs are 1 and `lock_count` holds at 16385.
- R8: A request-down seen in LOCK_WAIT or DRIVE returns the block to OFF with `lock_count` at 0. The next request-up counts again from 0.
- R9: `drv_en` is never 1 unless `term_en` and `pll_run` are also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_run | input | 1 | Power-down input; 0 requests power-down |
| vin_ok | input | 1 | Input supply present flag |
| drv_en | output | 1 | Serial driver enable |
| term_en | output | 1 | Internal termination enable |
| pll_run | output | 1 | PLL run control |
| ready | output | 1 | Releases the framer |
| lock_count | output | 15 | Lock-wait counter value |

## Verification
Every input change goes through the two synchronizer flops and then the state register, so the output effect of a change applied before edge E is first visible after edge E+2. The bench applies each stimulus just after a sample point. It then waits an exact number of rising edges and samples 1 ns after the last one. In LOCK_WAIT, `lock_count` equals the number of edges since the first LOCK_WAIT cycle, so the bench predicts 16384 on the last waiting cycle and the drive enable on the edge after it. Each abort case is sampled once after two edges, while the old state must still hold, and once after the third edge, when OFF must appear.

// File: rtl/link_power_seq_pkg.sv
package link_power_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRIVE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/lps_lock_counter.sv
module lps_lock_counter #(
    parameter int LOCK_CYCLES = 16385,
    parameter int CNT_W       = $clog2(LOCK_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(LOCK_CYCLES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (en)    cnt <= cnt + CNT_W'(1);
    end

    assign last = (cnt == TERM - CNT_W'(1));

    // R6: the count stops at the terminal value
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TERM);
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import link_power_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic last,
    output logic cnt_clear,
    output logic cnt_en,
    output logic drv_en,
    output logic term_en,
    output logic pll_run,
    output logic ready
);
    seq_state_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF:   if (req) nxt = ST_WAIT;
            ST_WAIT:  if (!req) nxt = ST_OFF;
                      else if (last) nxt = ST_DRIVE;
            ST_DRIVE: if (!req) nxt = ST_OFF;
            default:  nxt = ST_OFF;
        endcase
    end

    always_comb begin
        drv_en  = 1'b0;
        term_en = 1'b0;
        pll_run = 1'b0;
        ready   = 1'b0;
        unique case (st)
            ST_OFF: ;
            ST_WAIT: begin
                term_en = 1'b1;
                pll_run = 1'b1;
            end
            ST_DRIVE: begin
                drv_en  = 1'b1;
                term_en = 1'b1;
                pll_run = 1'b1;
                ready   = 1'b1;
            end
            default: ;
        endcase
    end

    assign cnt_clear = !req || (st == ST_OFF);
    assign cnt_en    = (st == ST_WAIT);

    // R9: the driver never runs without termination and PLL
    a_r9_drive_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (term_en && pll_run));

    // R4: DRIVE is only reached from the lock wait
    a_r4_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> $past(term_en));
endmodule

// File: rtl/link_power_seq.sv
module link_power_seq #(
    parameter int LOCK_CYCLES = 16385,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(LOCK_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_run,
    input  logic             vin_ok,
    output logic             drv_en,
    output logic             term_en,
    output logic             pll_run,
    output logic             ready,
    output logic [CNT_W-1:0] lock_count
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(LOCK_CYCLES);

    logic req_raw, req_s, last, cnt_clear, cnt_en;

    // R3: a missing input supply forces power-down
    assign req_raw = pwr_run & vin_ok;

    lps_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_raw),
        .q     (req_s)
    );

    lps_lock_counter #(.LOCK_CYCLES(LOCK_CYCLES), .CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .en    (cnt_en),
        .cnt   (lock_count),
        .last  (last)
    );

    lps_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_s),
        .last      (last),
        .cnt_clear (cnt_clear),
        .cnt_en    (cnt_en),
        .drv_en    (drv_en),
        .term_en   (term_en),
        .pll_run   (pll_run),
        .ready     (ready)
    );

    // R2 / R8: outside the wait and drive states the count is zero
    a_r8_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !term_en |-> (lock_count == '0));

    // R6: the driver rises exactly at the terminal count
    a_r6_rise_at_term: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> (lock_count == TERM));

    // R6: ready tracks the driver enable
    a_r6_ready_match: assert property (@(posedge clk) disable iff (!rst_n)
        ready == drv_en);

    // R5: one step per cycle while waiting
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (term_en && !drv_en && $past(term_en && !drv_en))
            |-> (lock_count == $past(lock_count) + CNT_W'(1)));

    // R7: count holds while driving
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && $past(drv_en)) |-> $stable(lock_count));

    // R3 / R8: a synchronized request-down leads to OFF
    a_r3_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !req_s |=> (!term_en && !drv_en));
endmodule

// File: tb/test_link_power_seq.sv
`timescale 1ns/1ps
module test_link_power_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_run = 1'b0;
    logic        vin_ok = 1'b0;
    logic        drv_en, term_en, pll_run, ready;
    logic [14:0] lock_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    link_power_seq i_link_power_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_run    (pwr_run),
        .vin_ok     (vin_ok),
        .drv_en     (drv_en),
        .term_en    (term_en),
        .pll_run    (pll_run),
        .ready      (ready),
        .lock_count (lock_count)
    );

    typedef struct packed {
        logic        run;
        logic        vin;
        logic [31:0] edges;
        logic [3:0]  req;
        logic        drv;
        logic        term;
        logic        pll;
        logic        rdy;
        logic [14:0] cnt;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 32'd2,     4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 15'd0},     // R4 still OFF after two edges
        '{1'b1, 1'b1, 32'd1,     4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 15'd0},     // R5 wait entered, count 0
        '{1'b1, 1'b1, 32'd100,   4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 15'd100},   // R5 counting
        '{1'b1, 1'b1, 32'd16284, 4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 15'd16384}, // R6 last wait cycle
        '{1'b1, 1'b1, 32'd1,     4'd6, 1'b1, 1'b1, 1'b1, 1'b1, 15'd16385}, // R6 drive and ready rise
        '{1'b1, 1'b1, 32'd50,    4'd7, 1'b1, 1'b1, 1'b1, 1'b1, 15'd16385}, // R7 count holds
        '{1'b0, 1'b1, 32'd2,     4'd4, 1'b1, 1'b1, 1'b1, 1'b1, 15'd16385}, // R4 drop not yet seen
        '{1'b0, 1'b1, 32'd1,     4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 15'd0},     // R8 DRIVE to OFF
        '{1'b1, 1'b1, 32'd3,     4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 15'd0},     // R8 restart at zero
        '{1'b1, 1'b1, 32'd500,   4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 15'd500},   // R5 counting
        '{1'b1, 1'b0, 32'd2,     4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 15'd502},   // R4 supply loss in flight
        '{1'b1, 1'b0, 32'd1,     4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 15'd0},     // R3 supply loss forces OFF
        '{1'b1, 1'b1, 32'd13,    4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 15'd10},    // R5 new wait
        '{1'b0, 1'b1, 32'd30,    4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 15'd0}      // R2 abort, stays OFF
    };

    task automatic check_obs(input string tag, input logic [18:0] exp_v);
        logic [18:0] act;
        act = {drv_en, term_en, pll_run, ready, lock_count};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual drv/term/pll/rdy=%b cnt=%0d expected drv/term/pll/rdy=%b cnt=%0d",
                     tag, act[18:15], act[14:0], exp_v[18:15], exp_v[14:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        fails++;
        $display("FAIL watchdog: actual run still busy expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        #7;
        check_obs("R1 reset", 19'd0);
        pwr_run = 1'b1;
        vin_ok  = 1'b1;
        #5;
        check_obs("R1 reset ignores request", 19'd0);
        @(negedge clk);
        rst_n = 1'b1;
        pwr_run = 1'b0;
        @(posedge clk);
        #1;

        for (int i = 0; i < NV; i++) begin
            pwr_run = TBL[i].run;
            vin_ok  = TBL[i].vin;
            for (int k = 0; k < int'(TBL[i].edges); k++) @(posedge clk);
            #1;
            check_obs($sformatf("R%0d row %0d", TBL[i].req, i),
                      {TBL[i].drv, TBL[i].term, TBL[i].pll, TBL[i].rdy, TBL[i].cnt});
        end

        // R7 / R1: reach DRIVE, then reset asynchronously
        pwr_run = 1'b1;
        vin_ok  = 1'b1;
        repeat (3 + 16385) @(posedge clk);
        #1;
        check_obs("R7 drive reached again", {4'b1111, 15'd16385});
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_obs("R1 async reset from DRIVE", 19'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_obs("R4 synchronizer refills after reset", 19'd0);
        @(posedge clk);
        #1;
        check_obs("R5 wait after reset release", {4'b0110, 15'd0});

        // R3: supply absent with pin high never leaves OFF
        vin_ok = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_obs("R3 supply absent", 19'd0);
        repeat (20) @(posedge clk);
        #1;
        check_obs("R3 supply absent holds OFF", 19'd0);

        finish_run();
    end
endmodule